// File: doc/BRIEF.md
# Menu-Driven Serial Flash Command Engine

This block runs single commands on a one-lane SPI flash bus for software that drives it through a byte-wide register port. Software does not write opcodes directly. It fills an eight-entry opcode menu and gives each entry a two-bit kind. The kind says whether a 24-bit address follows the opcode and whether the data phase reads or writes. To run a command, software picks a menu slot, sets a byte count and a data-phase enable, then sets the start bit. The engine shifts out the opcode, the address and any write data from a 64-byte buffer. For read kinds it captures the flash reply into that same buffer.

A prefix opcode can be sent just before the main command as a separate chip-select frame. This keeps a write-enable bound to the command that follows it. A one-way lock bit freezes the menu, the kind table and the prefix register until reset. The SPI bus runs in mode 0 at half the system clock rate. Each byte takes 16 system cycles.

Top module: `sflash_cmd_engine`

## Requirements
- R1: Each menu slot i (offsets 0x10 + i, i = 0..7) holds an opcode. Its kind sits at bits 2i+1:2i of the 16-bit kind table (low byte at 0x0A, high byte at 0x0B). The kinds are 0 = read without address, 1 = write without address, 2 = read with address, 3 = write with address. The opcode sent is the one in the selected slot.
- R2: The control word's high byte at 0x02 holds the byte count minus one in bits 5:0 and the data-phase enable in bit 6. Writing the low byte at 0x01 with bit 1 set starts a cycle. In that low byte, bit 2 requests the prefix and bits 6:4 pick the menu slot. The high byte reads back as written.
- R3: The status register at 0x00 shows busy in bit 0, done in bit 2 and error in bit 3, and all three read 0 after reset. Writing 1 to bit 2 or to bit 3 clears that bit.
- R4: For kinds 2 and 3, the 24-bit address (0x04 least significant byte to 0x06 most significant byte) follows the opcode, most significant byte first.
- R5: With the data phase enabled, a write kind sends count bytes (1 to 64) from buffer offsets 0x40 upward, starting at buffer byte 0.
- R6: With the data phase enabled, a read kind sends zero bytes on MOSI. It stores each byte received on MISO into the buffer, starting at byte 0, in the order received.
- R7: When the prefix is requested, the prefix opcode (0x08) is sent alone in its own chip-select frame. CS_n then stays high for GAP_CYC cycles, and then the main frame starts.
- R8: After 1 is written to bit 0 of 0x0C, writes to the menu, the kind table and the prefix register have no effect until reset.
- R9: With the data phase disabled, the frame holds only the opcode plus, for kinds 2 and 3, the address.
- R10: Busy reads 1 in the cycle after the start write. It falls in the same cycle that done sets. A start write made while busy is ignored.
- R11: The bus runs in SPI mode 0, MSB first, with SCLK at half the clock rate. CS_n stays low through the whole frame, for 16 cycles per byte. SCLK is low whenever CS_n is high.
- R12: Starting a cycle on a slot whose opcode is 0x00 sets the error bit and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
Busy must be readable in the cycle right after the start write. CS_n must fall on that same edge and stay low for exactly 16 cycles per byte. With a prefix, 16 cycles of prefix frame come first, followed by exactly GAP_CYC cycles high. Each time a cycle is accepted, the bench queues the expected CS_n level for every clock. It pops one entry at each rising edge and compares the pin at the falling edge, so any lost or extra cycle shows up on the exact clock it happens. Frame contents, buffer bytes and status flags are read only after that queue has drained, which means after done has been set.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int REG_AW     = 7;
    localparam int MENU_N     = 8;
    localparam int MENU_AW    = $clog2(MENU_N);
    localparam int DBUF_BYTES = 64;
    localparam int DBUF_AW    = $clog2(DBUF_BYTES);
    localparam int ADDR_BYTES = 3;
    localparam int BIDX_W     = $clog2(1 + ADDR_BYTES + DBUF_BYTES + 1);

    localparam logic [REG_AW-1:0] OFS_STAT   = 7'h00;
    localparam logic [REG_AW-1:0] OFS_CTL_LO = 7'h01;
    localparam logic [REG_AW-1:0] OFS_CTL_HI = 7'h02;
    localparam logic [REG_AW-1:0] OFS_ADR0   = 7'h04;
    localparam logic [REG_AW-1:0] OFS_PFX    = 7'h08;
    localparam logic [REG_AW-1:0] OFS_TYP_LO = 7'h0A;
    localparam logic [REG_AW-1:0] OFS_TYP_HI = 7'h0B;
    localparam logic [REG_AW-1:0] OFS_LOCK   = 7'h0C;
    localparam logic [REG_AW-1:0] OFS_MENU   = 7'h10;
    localparam logic [REG_AW-1:0] OFS_BUF    = 7'h40;

    typedef enum logic [1:0] {
        K_RD_NOADR = 2'd0,
        K_WR_NOADR = 2'd1,
        K_RD_ADR   = 2'd2,
        K_WR_ADR   = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PFX,
        ST_GAP,
        ST_MAIN
    } seq_st_e;

    typedef struct packed {
        logic [7:0]               opc;
        kind_e                    kind;
        logic [8*ADDR_BYTES-1:0]  addr;
        logic [DBUF_AW-1:0]       cnt_m1;
        logic                     data_en;
        logic                     atomic;
        logic [7:0]               pfx;
    } cmd_t;

    function automatic logic kind_has_addr(kind_e k);
        return k[1];
    endfunction

    function automatic logic kind_is_write(kind_e k);
        return k[0];
    endfunction
endpackage

// File: rtl/sfe_regs.sv
module sfe_regs
    import sfe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [REG_AW-1:0]   addr,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic                busy,
    input  logic                done_set,
    input  logic                err_set,
    input  logic                seq_we,
    input  logic [DBUF_AW-1:0]  seq_widx,
    input  logic [7:0]          seq_wbyte,
    input  logic [DBUF_AW-1:0]  seq_ridx,
    output logic [7:0]          seq_rbyte,
    output logic                go_req,
    output cmd_t                cmd
);
    logic                     done_q, err_q, lock_q;
    logic [7:0]               ctl_lo_q, ctl_hi_q, pfx_q;
    logic [8*ADDR_BYTES-1:0]  addr_q;
    logic [2*MENU_N-1:0]      type_q;
    logic [7:0]               menu_q [MENU_N];
    logic [7:0]               dbuf_q [DBUF_BYTES];

    logic                     in_menu, in_buf;
    logic [MENU_AW-1:0]       menu_idx, go_idx;
    logic [DBUF_AW-1:0]       buf_idx;

    assign in_menu  = addr[REG_AW-1:MENU_AW] == OFS_MENU[REG_AW-1:MENU_AW];
    assign in_buf   = addr[REG_AW-1:DBUF_AW] == OFS_BUF[REG_AW-1:DBUF_AW];
    assign menu_idx = addr[MENU_AW-1:0];
    assign buf_idx  = addr[DBUF_AW-1:0];

    assign go_req = we && (addr == OFS_CTL_LO) && wdata[1];
    assign go_idx = wdata[4 +: MENU_AW];

    always_comb begin
        cmd.opc     = menu_q[go_idx];
        cmd.kind    = kind_e'(type_q[{go_idx, 1'b0} +: 2]);
        cmd.addr    = addr_q;
        cmd.cnt_m1  = ctl_hi_q[DBUF_AW-1:0];
        cmd.data_en = ctl_hi_q[6];
        cmd.atomic  = wdata[2];
        cmd.pfx     = pfx_q;
    end

    assign seq_rbyte = dbuf_q[seq_ridx];

    // status flags: set pulses win over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (we && addr == OFS_STAT && wdata[2]) done_q <= 1'b0;
            if (we && addr == OFS_STAT && wdata[3]) err_q  <= 1'b0;
            if (done_set) done_q <= 1'b1;
            if (err_set)  err_q  <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_lo_q <= '0;
            ctl_hi_q <= '0;
            addr_q   <= '0;
            pfx_q    <= '0;
            type_q   <= '0;
            lock_q   <= 1'b0;
            for (int i = 0; i < MENU_N; i++) menu_q[i] <= '0;
        end else if (we) begin
            if (addr == OFS_CTL_LO) ctl_lo_q <= wdata & 8'hFD;
            if (addr == OFS_CTL_HI) ctl_hi_q <= wdata;
            for (int b = 0; b < ADDR_BYTES; b++)
                if (addr == OFS_ADR0 + REG_AW'(b)) addr_q[8*b +: 8] <= wdata;
            if (addr == OFS_LOCK && wdata[0]) lock_q <= 1'b1;
            if (!lock_q) begin
                if (addr == OFS_PFX)    pfx_q       <= wdata;
                if (addr == OFS_TYP_LO) type_q[7:0]  <= wdata;
                if (addr == OFS_TYP_HI) type_q[15:8] <= wdata;
                if (in_menu)            menu_q[menu_idx] <= wdata;
            end
        end
    end

    // data buffer: the sequencer's capture port has priority
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DBUF_BYTES; i++) dbuf_q[i] <= '0;
        end else if (seq_we) begin
            dbuf_q[seq_widx] <= seq_wbyte;
        end else if (we && in_buf) begin
            dbuf_q[buf_idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (in_menu) begin
            rdata = menu_q[menu_idx];
        end else if (in_buf) begin
            rdata = dbuf_q[buf_idx];
        end else begin
            case (addr)
                OFS_STAT:          rdata = {4'b0, err_q, done_q, 1'b0, busy};
                OFS_CTL_LO:        rdata = ctl_lo_q;
                OFS_CTL_HI:        rdata = ctl_hi_q;
                OFS_ADR0:          rdata = addr_q[7:0];
                OFS_ADR0 + 7'd1:   rdata = addr_q[15:8];
                OFS_ADR0 + 7'd2:   rdata = addr_q[23:16];
                OFS_PFX:           rdata = pfx_q;
                OFS_TYP_LO:        rdata = type_q[7:0];
                OFS_TYP_HI:        rdata = type_q[15:8];
                OFS_LOCK:          rdata = {7'b0, lock_q};
                default:           rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       load,
    input  logic [7:0] ld_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    logic [7:0] sh_q, rx_q;
    logic [2:0] bit_q;
    logic       ph_q, sclk_q;

    assign sclk      = sclk_q;
    assign mosi      = sh_q[7];
    assign rx_byte   = rx_q;
    assign byte_done = active && ph_q && (bit_q == 3'd7);

    // phase 0: raise SCLK and sample MISO; phase 1: drop SCLK and shift
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rx_q   <= '0;
            bit_q  <= '0;
            ph_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else if (load) begin
            sh_q   <= ld_byte;
            bit_q  <= '0;
            ph_q   <= 1'b0;
            sclk_q <= 1'b0;
        end else if (active) begin
            if (!ph_q) begin
                sclk_q <= 1'b1;
                ph_q   <= 1'b1;
                rx_q   <= {rx_q[6:0], miso};
            end else begin
                sclk_q <= 1'b0;
                ph_q   <= 1'b0;
                sh_q   <= {sh_q[6:0], 1'b0};
                bit_q  <= bit_q + 3'd1;
            end
        end
    end
endmodule

// File: rtl/sfe_seq.sv
module sfe_seq
    import sfe_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go_req,
    input  cmd_t                cmd_in,
    input  logic                byte_done,
    input  logic [7:0]          rx_byte,
    input  logic [7:0]          buf_rbyte,
    output logic [DBUF_AW-1:0]  buf_ridx,
    output logic                buf_we,
    output logic [DBUF_AW-1:0]  buf_widx,
    output logic [7:0]          buf_wbyte,
    output logic                load,
    output logic [7:0]          ld_byte,
    output logic                active,
    output logic                cs_n,
    output logic                busy,
    output logic                done_set,
    output logic                err_set
);
    localparam int GAP_CW = $clog2(GAP_CYC + 1);

    seq_st_e                  st_q;
    logic [7:0]               opc_q;
    kind_e                    kind_q;
    logic [8*ADDR_BYTES-1:0]  adr_q;
    logic [DBUF_AW-1:0]       cnt_q;
    logic                     den_q;
    logic [BIDX_W-1:0]        bidx_q, hdr, nbytes, nxt_k;
    logic [GAP_CW-1:0]        gap_q;
    logic                     start_ok, last, gap_end;

    assign start_ok = go_req && (st_q == ST_IDLE) && (cmd_in.opc != 8'h00);
    assign err_set  = go_req && (st_q == ST_IDLE) && (cmd_in.opc == 8'h00);

    assign hdr    = kind_has_addr(kind_q) ? BIDX_W'(1 + ADDR_BYTES) : BIDX_W'(1);
    assign nbytes = hdr + (den_q ? (BIDX_W'(cnt_q) + BIDX_W'(1)) : '0);
    assign last   = (bidx_q == nbytes - BIDX_W'(1));
    assign nxt_k  = bidx_q + BIDX_W'(1);
    assign gap_end = (gap_q == GAP_CW'(GAP_CYC - 1));

    assign active = (st_q == ST_PFX) || (st_q == ST_MAIN);
    assign cs_n   = !active;
    assign busy   = (st_q != ST_IDLE);

    assign buf_ridx  = DBUF_AW'(nxt_k - hdr);
    assign buf_widx  = DBUF_AW'(bidx_q - hdr);
    assign buf_wbyte = rx_byte;

    function automatic logic [7:0] frame_byte(input logic [BIDX_W-1:0] k,
                                              input logic [BIDX_W-1:0] h);
        if (k == '0)
            return opc_q;
        if (k < h)
            return 8'(adr_q >> (8 * (ADDR_BYTES - int'(k))));
        return kind_is_write(kind_q) ? buf_rbyte : 8'h00;
    endfunction

    always_comb begin
        load     = 1'b0;
        ld_byte  = 8'h00;
        buf_we   = 1'b0;
        done_set = 1'b0;
        case (st_q)
            ST_IDLE: if (start_ok) begin
                load    = 1'b1;
                ld_byte = cmd_in.atomic ? cmd_in.pfx : cmd_in.opc;
            end
            ST_GAP: if (gap_end) begin
                load    = 1'b1;
                ld_byte = opc_q;
            end
            ST_MAIN: if (byte_done) begin
                buf_we = (bidx_q >= hdr) && !kind_is_write(kind_q);
                if (last) begin
                    done_set = 1'b1;
                end else begin
                    load    = 1'b1;
                    ld_byte = frame_byte(nxt_k, hdr);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            opc_q  <= '0;
            kind_q <= K_RD_NOADR;
            adr_q  <= '0;
            cnt_q  <= '0;
            den_q  <= 1'b0;
            bidx_q <= '0;
            gap_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start_ok) begin
                    opc_q  <= cmd_in.opc;
                    kind_q <= cmd_in.kind;
                    adr_q  <= cmd_in.addr;
                    cnt_q  <= cmd_in.cnt_m1;
                    den_q  <= cmd_in.data_en;
                    bidx_q <= '0;
                    gap_q  <= '0;
                    st_q   <= cmd_in.atomic ? ST_PFX : ST_MAIN;
                end
                ST_PFX: if (byte_done) st_q <= ST_GAP;
                ST_GAP: begin
                    gap_q <= gap_q + GAP_CW'(1);
                    if (gap_end) st_q <= ST_MAIN;
                end
                ST_MAIN: if (byte_done) begin
                    if (last) st_q <= ST_IDLE;
                    else      bidx_q <= nxt_k;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sflash_cmd_engine.sv
module sflash_cmd_engine
    import sfe_pkg::*;
#(
    parameter int GAP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    cmd_t               cmd_w;
    logic               go_w, busy_w, done_set_w, err_set_w;
    logic               seq_we_w, load_w, active_w, byte_done_w;
    logic [DBUF_AW-1:0] widx_w, ridx_w;
    logic [7:0]         wbyte_w, rbyte_w, ld_byte_w, rx_byte_w;

    sfe_regs u_regs (
        .clk(clk), .rst(rst),
        .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .busy(busy_w), .done_set(done_set_w), .err_set(err_set_w),
        .seq_we(seq_we_w), .seq_widx(widx_w), .seq_wbyte(wbyte_w),
        .seq_ridx(ridx_w), .seq_rbyte(rbyte_w),
        .go_req(go_w), .cmd(cmd_w)
    );

    sfe_seq #(.GAP_CYC(GAP_CYC)) u_seq (
        .clk(clk), .rst(rst),
        .go_req(go_w), .cmd_in(cmd_w),
        .byte_done(byte_done_w), .rx_byte(rx_byte_w),
        .buf_rbyte(rbyte_w), .buf_ridx(ridx_w),
        .buf_we(seq_we_w), .buf_widx(widx_w), .buf_wbyte(wbyte_w),
        .load(load_w), .ld_byte(ld_byte_w),
        .active(active_w), .cs_n(spi_cs_n), .busy(busy_w),
        .done_set(done_set_w), .err_set(err_set_w)
    );

    sfe_shifter u_shift (
        .clk(clk), .rst(rst),
        .active(active_w), .load(load_w), .ld_byte(ld_byte_w),
        .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
        .byte_done(byte_done_w), .rx_byte(rx_byte_w)
    );
endmodule

// File: rtl/sfe_chk.sv
module sfe_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic cs_n,
    input logic sclk,
    input logic done_set,
    input logic err_set
);
    p_cs_idle_r11: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n);
    p_sclk_rest_r11: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
    p_flag_excl_r3: assert property (@(posedge clk) disable iff (rst) $onehot0({done_set, err_set}));
    p_done_busy_r10: assert property (@(posedge clk) disable iff (rst) done_set |-> busy);
    p_fall_done_r10: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> $past(done_set));
    p_err_idle_r12: assert property (@(posedge clk) disable iff (rst) err_set |=> !busy);
endmodule

bind sflash_cmd_engine sfe_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy_w), .cs_n(spi_cs_n),
    .sclk(spi_sclk), .done_set(done_set_w), .err_set(err_set_w)
);

// File: tb/tb_sflash_cmd_engine.sv
module tb_sflash_cmd_engine;
    localparam int GAP = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [6:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi;
    logic       miso_r = 1'b0;

    int errors = 0;
    int checks = 0;
    bit started = 0;

    always #5 clk = ~clk;

    sflash_cmd_engine #(.GAP_CYC(GAP)) dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(miso_r)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- per-clock CS_n reference model ----------------
    bit mq[$];
    bit exp_cs = 1'b1;
    always @(posedge clk) begin
        if (mq.size() > 0) exp_cs <= mq.pop_front();
        else               exp_cs <= 1'b1;
    end
    always @(negedge clk) begin
        if (started) chk(spi_cs_n === exp_cs, "R11 R7 cs_n per-clock", int'(spi_cs_n), int'(exp_cs));
    end

    // ---------------- flash slave model ----------------
    int rxq[$];
    int flq[$];
    int eq[$];
    int el[$];
    int sl_bit = 0, sl_k = 0, sl_len = 0;
    logic [7:0] sl_cur = '0, sl_t = '0;

    function automatic logic [7:0] pat(int k);
        return 8'(32'hC0 + k);
    endfunction

    always @(negedge spi_cs_n) begin
        sl_bit = 0; sl_k = 0; sl_len = 0;
        sl_t = pat(0);
        miso_r = sl_t[7];
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            sl_cur = {sl_cur[6:0], spi_mosi};
            sl_bit++;
            if (sl_bit == 8) begin
                rxq.push_back(int'(sl_cur));
                sl_bit = 0; sl_k++; sl_len++;
            end
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            sl_t = pat(sl_k);
            miso_r = sl_t[7 - sl_bit];
        end
    end
    always @(posedge spi_cs_n) begin
        if (started) flq.push_back(sl_len);
    end

    // ---------------- bench copy of menu kinds ----------------
    logic [1:0] bk [8];

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic go(input int idx, input bit atom, input int cm1, input bit den,
                      input bit runs, output logic [7:0] st_after);
        int n;
        wr(7'h02, {1'b0, den, 6'(cm1)});
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'h01;
        reg_wdata = {1'b0, 3'(idx), 1'b0, atom, 1'b1, 1'b0};
        if (runs) begin
            n = 1 + (bk[idx][1] ? 3 : 0) + (den ? cm1 + 1 : 0);
            if (atom) begin
                repeat (16) mq.push_back(1'b0);
                repeat (GAP) mq.push_back(1'b1);
            end
            repeat (16 * n) mq.push_back(1'b0);
        end
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 7'h00;
        #1 st_after = reg_rdata;
    endtask

    task automatic wait_idle();
        while (mq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_frames(input string req);
        bit ok = 1;
        int bad_a = 0, bad_e = 0;
        if (rxq.size() != eq.size()) begin ok = 0; bad_a = rxq.size(); bad_e = eq.size(); end
        else foreach (eq[i]) if (ok && rxq[i] != eq[i]) begin ok = 0; bad_a = rxq[i]; bad_e = eq[i]; end
        chk(ok, {req, " frame bytes"}, bad_a, bad_e);
        ok = (flq.size() == el.size());
        if (ok) foreach (el[i]) if (flq[i] != el[i]) ok = 0;
        chk(ok, {req, " frame lengths"}, flq.size(), el.size());
        rxq.delete(); flq.delete(); eq.delete(); el.delete();
    endtask

    task automatic push_hdr(input int opc, input bit adr);
        eq.push_back(opc);
        if (adr) begin eq.push_back('h12); eq.push_back('h34); eq.push_back('h56); end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v, s;
        bk[0] = 2'd1; bk[1] = 2'd2; bk[2] = 2'd3; bk[3] = 2'd0;
        bk[4] = 2'd0; bk[5] = 2'd0; bk[6] = 2'd0; bk[7] = 2'd0;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        started = 1;

        // reset state
        rd(7'h00, v); chk(v == 8'h00, "R3 status after reset", v, 0);
        chk(spi_cs_n === 1'b1 && spi_sclk === 1'b0, "R11 idle bus after reset", {spi_cs_n, spi_sclk}, 2);

        // program menu, kinds, prefix, address
        wr(7'h10, 8'h06); wr(7'h11, 8'h03); wr(7'h12, 8'h02); wr(7'h13, 8'h05);
        wr(7'h0A, 8'h39);
        wr(7'h08, 8'h06);
        wr(7'h04, 8'h56); wr(7'h05, 8'h34); wr(7'h06, 8'h12);
        rd(7'h11, v); chk(v == 8'h03, "R1 menu readback", v, 3);

        // opcode only, no data phase
        go(0, 0, 0, 0, 1, s);
        chk(s[0] == 1'b1, "R10 busy the cycle after start", s[0], 1);
        wait_idle();
        push_hdr('h06, 0); el.push_back(1);
        check_frames("R9 R1 opcode-only");
        rd(7'h00, v); chk(v == 8'h04, "R3 done set busy clear", v, 4);
        wr(7'h00, 8'h04);
        rd(7'h00, v); chk(v == 8'h00, "R3 done cleared by writing 1", v, 0);
        rd(7'h02, v); chk(v == 8'h00, "R2 control high readback", v, 0);

        // address write with 4 data bytes
        for (int i = 0; i < 4; i++) wr(7'(7'h40 + i), 8'(8'hA0 + i));
        go(2, 0, 3, 1, 1, s);
        wait_idle();
        push_hdr('h02, 1);
        for (int i = 0; i < 4; i++) eq.push_back('hA0 + i);
        el.push_back(8);
        check_frames("R4 R5 write with address");
        rd(7'h02, v); chk(v == 8'h43, "R2 control high readback", v, 'h43);

        // address read of 3 bytes
        go(1, 0, 2, 1, 1, s);
        wait_idle();
        push_hdr('h03, 1);
        for (int i = 0; i < 3; i++) eq.push_back(0);
        el.push_back(7);
        check_frames("R6 read with address");
        for (int i = 0; i < 3; i++) begin
            rd(7'(7'h40 + i), v);
            chk(v == pat(4 + i), "R6 captured byte order", v, pat(4 + i));
        end
        rd(7'h43, v); chk(v == 8'hA3, "R6 bytes beyond count untouched", v, 'hA3);

        // read without address, 2 bytes
        go(3, 0, 1, 1, 1, s);
        wait_idle();
        push_hdr('h05, 0); eq.push_back(0); eq.push_back(0); el.push_back(3);
        check_frames("R6 read without address");
        rd(7'h40, v); chk(v == pat(1), "R6 no-address capture byte 0", v, pat(1));
        rd(7'h41, v); chk(v == pat(2), "R6 no-address capture byte 1", v, pat(2));

        // prefix frame then main command
        go(2, 1, 0, 1, 1, s);
        wait_idle();
        eq.push_back('h06); push_hdr('h02, 1); eq.push_back(pat(1));
        el.push_back(1); el.push_back(5);
        check_frames("R7 prefix frame");

        // full 64-byte write, with an ignored start in the middle
        for (int i = 0; i < 64; i++) wr(7'(7'h40 + i), 8'(i) ^ 8'h5A);
        go(2, 0, 63, 1, 1, s);
        repeat (200) @(negedge clk);
        reg_we = 1'b1; reg_addr = 7'h01; reg_wdata = 8'h02;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 7'h00;
        #1 chk(reg_rdata[0] == 1'b1, "R10 start while busy ignored, still busy", reg_rdata[0], 1);
        wait_idle();
        push_hdr('h02, 1);
        for (int i = 0; i < 64; i++) eq.push_back(int'(8'(i) ^ 8'h5A));
        el.push_back(68);
        check_frames("R5 R10 64-byte write");

        // empty menu slot
        wr(7'h00, 8'h04);
        go(4, 0, 0, 0, 0, s);
        chk(s[0] == 1'b0, "R12 empty slot never busy", s[0], 0);
        repeat (4) @(negedge clk);
        rd(7'h00, v); chk(v == 8'h08, "R12 error flag", v, 8);
        chk(rxq.size() == 0 && flq.size() == 0, "R12 nothing sent", flq.size(), 0);
        wr(7'h00, 8'h08);
        rd(7'h00, v); chk(v == 8'h00, "R3 error cleared by writing 1", v, 0);

        // lock
        wr(7'h0C, 8'h01);
        wr(7'h10, 8'hAA); wr(7'h0A, 8'hFF); wr(7'h08, 8'h99);
        rd(7'h10, v); chk(v == 8'h06, "R8 menu frozen", v, 6);
        rd(7'h0A, v); chk(v == 8'h39, "R8 kind table frozen", v, 'h39);
        rd(7'h08, v); chk(v == 8'h06, "R8 prefix frozen", v, 6);
        go(0, 0, 0, 0, 1, s);
        wait_idle();
        push_hdr('h06, 0); el.push_back(1);
        check_frames("R8 locked menu still sends old opcode");

        started = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule